// File: doc/BRIEF.md
# Dual-target SPI command master

This block is an SPI master that serves two peripherals on separate active-low chip selects. One is a logic device that takes 16-bit command frames. The other is a display that takes 9-bit words. The host offers a word on a valid/ready stream: a target bit, a 4-bit command code and a 12-bit data value. When the stream is accepted, the block latches the target, builds the frame for that target and shifts it out most significant bit first. SCK idles low, and each bit is presented before the rising edge that samples it.

The block makes all of its own timing. SCK runs at one sixth of the system clock. A one-clock setup separates the chip-select assertion from the first SCK edge. The chip select is released after every frame, and a fixed idle gap follows before the next word can go out. MISO is sampled on each rising SCK edge, and the received word is presented with a one-cycle valid pulse when the frame ends.

Stream rules: a word is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is the transmit-empty flag. While it is low, the host must hold its word, and the block neither samples nor uses that word. `busy` is the complement of `in_ready` and is provided as a plain status pin.

Top module: `spi_dual_master`

## Requirements
- R1: After reset, both chip selects are high, SCK and MOSI are low, `in_ready` is high and `busy` is low.
- R2: A word is accepted on the edge where `in_valid` and `in_ready` are both high. From the next cycle, `busy` is high and `in_ready` is low until the gap ends. A word offered while `in_ready` is low has no effect on the frame in progress, and it is sent only after `in_ready` returns.
- R3: Target 0 drives `cs_n[0]` low and sends 16 bits MSB first, laid out as command in bits 15..12 and data in bits 11..0.
- R4: Target 1 drives `cs_n[1]` low and sends 9 bits MSB first, taken from data bits 8..0. The command and data bits 11..9 are ignored.
- R5: SCK is low whenever no chip select is asserted. During a frame it has a period of 6 system clocks, high for 3 and low for 3.
- R6: MOSI changes only on falling SCK edges, so it is stable from each rising edge through the whole high phase.
- R7: The first rising SCK edge comes exactly 1 system clock after the chip select falls.
- R8: The chip select rises on the same clock edge as the final falling SCK edge of the frame.
- R9: After a frame, the chip selects stay high for exactly 32 system clocks before the next chip select can fall. `in_ready` rises 31 clocks after the release.
- R10: MISO is sampled on every rising SCK edge. When the chip select is released, `rx_valid` pulses for one cycle, and `rx_data` then holds the received bits right-aligned, with the upper bits zero for a 9-bit frame.
- R11: At most one chip select is low at any time, and it is the one for the target latched when the word was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Transmit empty; word accepted when both valid and ready |
| in_target | input | 1 | 0 = logic device (16-bit), 1 = display (9-bit) |
| in_cmd | input | 4 | Command code for the logic device |
| in_data | input | 12 | Data value; low 9 bits used for the display |
| busy | output | 1 | High from acceptance until the gap ends |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects, index = target |
| rx_data | output | 16 | Bits received in the last frame, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
The bench loops MOSI back to MISO. It rebuilds every frame from the rising SCK edges and times each edge against the chip-select fall. These checks catch a design that drops the one-clock setup, shortens the final low phase, or uses the wrong SCK half-period. A display word whose data has its upper bits set exposes a design that does not truncate to 9 bits or that shifts from the wrong end. A word held on the stream with a different target during a transfer catches two faults: a design that resamples the target mid-frame, and one whose gap is one clock too short or too long before the held word goes out.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  localparam int DEF_CMD_W   = 4;
  localparam int DEF_DATA_W  = 12;
  localparam int DEF_DISP_W  = 9;
  localparam int DEF_CLK_DIV = 6;
  localparam int DEF_SETUP   = 1;
  localparam int DEF_GAP     = 32;
endpackage

// File: rtl/spi_frame_pack.sv
module spi_frame_pack #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int DISP_W = 9,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               target,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  logic [FRAME_W-1:0] disp_frame;

  // display word is left-aligned so both frames leave from the top bit
  generate
    if (DISP_W < FRAME_W) begin : g_pad
      assign disp_frame = {data[DISP_W-1:0], {(FRAME_W-DISP_W){1'b0}}};
    end else begin : g_nopad
      assign disp_frame = data[FRAME_W-1:0];
    end
  endgenerate

  always_comb begin
    if (target) begin
      frame = disp_frame;
      len   = LEN_W'(DISP_W);
    end else begin
      frame = {cmd, data};
      len   = LEN_W'(FRAME_W);
    end
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_dual_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CLK_DIV = 6,
  parameter int SETUP   = 1,
  parameter int GAP     = 32,
  localparam int LEN_W   = $clog2(FRAME_W + 1),
  localparam int HALF    = CLK_DIV / 2,
  localparam int DIV_W   = $clog2(CLK_DIV),
  localparam int SETUP_W = $clog2(SETUP + 1),
  localparam int GAP_W   = $clog2(GAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             target,
  input  logic [LEN_W-1:0] len,
  output logic             in_ready,
  output logic             load,
  output logic             sample,
  output logic             shift,
  output logic             done,
  output logic             sck,
  output logic [1:0]       cs_n
);
  seq_state_e         state;
  logic [DIV_W-1:0]   div_cnt;
  logic [SETUP_W-1:0] setup_cnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic [LEN_W-1:0]   bit_cnt;
  logic [LEN_W-1:0]   len_q;
  logic               at_fall;
  logic               at_rise;
  logic               last_bit;

  assign in_ready = (state == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign at_fall  = (state == ST_SHIFT) && (div_cnt == DIV_W'(HALF - 1));
  assign at_rise  = (state == ST_SHIFT) && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign last_bit = (bit_cnt == (len_q - LEN_W'(1)));
  assign sample   = ((state == ST_SETUP) && (setup_cnt == '0)) || at_rise;
  assign shift    = at_fall && !last_bit;
  assign done     = at_fall && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      div_cnt   <= '0;
      setup_cnt <= '0;
      gap_cnt   <= '0;
      bit_cnt   <= '0;
      len_q     <= '0;
      sck       <= 1'b0;
      cs_n      <= 2'b11;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            state     <= ST_SETUP;
            setup_cnt <= SETUP_W'(SETUP - 1);
            len_q     <= len;
            cs_n      <= target ? 2'b01 : 2'b10;
          end
        end
        ST_SETUP: begin
          if (setup_cnt == '0) begin
            state   <= ST_SHIFT;
            sck     <= 1'b1;
            div_cnt <= '0;
            bit_cnt <= '0;
          end else begin
            setup_cnt <= setup_cnt - SETUP_W'(1);
          end
        end
        ST_SHIFT: begin
          if (at_fall) begin
            sck     <= 1'b0;
            div_cnt <= div_cnt + DIV_W'(1);
            if (last_bit) begin
              state   <= ST_GAP;
              cs_n    <= 2'b11;
              gap_cnt <= GAP_W'(GAP - 2);
            end else begin
              bit_cnt <= bit_cnt + LEN_W'(1);
            end
          end else if (at_rise) begin
            sck     <= 1'b1;
            div_cnt <= '0;
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        default: begin
          if (gap_cnt == '0) state <= ST_IDLE;
          else               gap_cnt <= gap_cnt - GAP_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  input  logic               sample,
  input  logic               done,
  input  logic               miso,
  output logic               tx_msb,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_valid
);
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;

  assign tx_msb = tx_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= done;
      if (load) begin
        tx_sh <= frame;
        rx_sh <= '0;
      end else begin
        if (shift)  tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (sample) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
      end
      if (done) rx_data <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_dual_master.sv
module spi_dual_master
  import spi_dual_pkg::*;
#(
  parameter int CMD_W   = DEF_CMD_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int DISP_W  = DEF_DISP_W,
  parameter int CLK_DIV = DEF_CLK_DIV,
  parameter int SETUP   = DEF_SETUP,
  parameter int GAP     = DEF_GAP,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_target,
  input  logic [CMD_W-1:0]   in_cmd,
  input  logic [DATA_W-1:0]  in_data,
  output logic               busy,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [1:0]         cs_n,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_valid
);
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               load;
  logic               sample;
  logic               shift;
  logic               done;
  logic               tx_msb;

  spi_frame_pack #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W),
    .DISP_W(DISP_W)
  ) u_pack (
    .target(in_target),
    .cmd   (in_cmd),
    .data  (in_data),
    .frame (frame),
    .len   (len)
  );

  spi_seq_ctrl #(
    .FRAME_W(FRAME_W),
    .CLK_DIV(CLK_DIV),
    .SETUP  (SETUP),
    .GAP    (GAP)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .target  (in_target),
    .len     (len),
    .in_ready(in_ready),
    .load    (load),
    .sample  (sample),
    .shift   (shift),
    .done    (done),
    .sck     (sck),
    .cs_n    (cs_n)
  );

  spi_shift_reg #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .frame   (frame),
    .shift   (shift),
    .sample  (sample),
    .done    (done),
    .miso    (miso),
    .tx_msb  (tx_msb),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  assign busy = !in_ready;
  assign mosi = (&cs_n) ? 1'b0 : tx_msb;
endmodule

// File: rtl/spi_dual_master_chk.sv
module spi_dual_master_chk #(
  parameter int SETUP = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       busy,
  input logic       sck,
  input logic       mosi,
  input logic [1:0] cs_n,
  input logic       rx_valid
);
  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_n) >= 1); // R11

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck); // R5

  AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi)); // R6

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready)); // R2

  AST_NOT_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n) |-> !in_ready); // R9

  AST_RXV_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(&cs_n)); // R10

  generate
    if (SETUP == 1) begin : g_setup1
      AST_CS_TO_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n[0]) || $fell(cs_n[1])) |=> $rose(sck)); // R7
    end
  endgenerate
endmodule

bind spi_dual_master spi_dual_master_chk #(
  .SETUP(SETUP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .busy    (busy),
  .sck     (sck),
  .mosi    (mosi),
  .cs_n    (cs_n),
  .rx_valid(rx_valid)
);

// File: tb/spi_dual_master_tb.sv
module spi_dual_master_tb;
  localparam int GAP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_target = 1'b0;
  logic [3:0]  in_cmd = '0;
  logic [11:0] in_data = '0;
  logic        busy;
  logic        sck;
  logic        mosi;
  logic        miso;
  logic [1:0]  cs_n;
  logic [15:0] rx_data;
  logic        rx_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;
  assign miso = mosi;

  spi_dual_master u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_target(in_target), .in_cmd(in_cmd), .in_data(in_data), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // {target, cmd, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 4'hA, 12'h5C3},
    {1'b0, 4'hF, 12'hFFF},
    {1'b0, 4'h0, 12'h000},
    {1'b1, 4'h3, 12'h1A5},
    {1'b1, 4'h7, 12'hE2B},
    {1'b0, 4'h5, 12'hA5A}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input bit tgt, input logic [3:0] c, input logic [11:0] d);
    return tgt ? {7'b0, d[8:0]} : {c, d};
  endfunction

  task automatic offer(input bit tgt, input logic [3:0] c, input logic [11:0] d);
    while (!in_ready) @(negedge clk);
    in_target = tgt; in_cmd = c; in_data = d; in_valid = 1'b1;
    @(negedge clk);
  endtask

  // called at the first negedge after the load edge
  task automatic observe(input bit tgt, input logic [15:0] expv, output int t_cs, output int t_rdy);
    logic [15:0] bits = '0;
    int nr = 0;
    int last = -1;
    bit prev = 1'b0;
    bit per_ok = 1'b1, hi_ok = 1'b1, cs_ok = 1'b1, stab_ok = 1'b1, idle_ok = 1'b1;
    logic held = 1'b0;
    logic [1:0] exp_cs = tgt ? 2'b01 : 2'b10;
    int exp_len = tgt ? 9 : 16;
    t_cs = -1; t_rdy = -1;
    check(cs_n == exp_cs, "R11 chip select for latched target", cs_n, exp_cs);
    check(busy && !in_ready, "R2 busy after accept", {busy, in_ready}, 2'b10);
    for (int t = 0; t < 1000; t++) begin
      if (sck && !prev) begin
        if (nr == 0) check(t == 1, "R7 CS to first rise", t, 1);
        else if (t - last != 6) per_ok = 1'b0;
        if (cs_n != exp_cs) cs_ok = 1'b0;
        bits = {bits[14:0], mosi};
        held = mosi;
        nr++;
        last = t;
      end else if (sck && mosi != held) begin
        stab_ok = 1'b0;
      end
      if (!sck && prev && t - last != 3) hi_ok = 1'b0;
      if (t_cs < 0 && cs_n == 2'b11) begin
        t_cs = t;
        check(t == last + 3, "R8 release on last falling edge", t, last + 3);
        check(rx_valid == 1'b1, "R10 rx_valid at release", rx_valid, 1);
        check(rx_data == expv, "R10 received word", rx_data, expv);
      end
      if (t_cs >= 0 && (sck || mosi)) idle_ok = 1'b0;
      if (t_cs >= 0 && t > t_cs && rx_valid) idle_ok = 1'b0;
      if (t_cs >= 0 && in_ready) begin
        t_rdy = t;
        break;
      end
      prev = sck;
      @(negedge clk);
    end
    check(nr == exp_len, tgt ? "R4 display bit count" : "R3 logic bit count", nr, exp_len);
    check(bits == expv, tgt ? "R4 display frame bits" : "R3 logic frame bits", bits, expv);
    check(per_ok && hi_ok, "R5 SCK period and high phase", {per_ok, hi_ok}, 2'b11);
    check(stab_ok, "R6 MOSI stable while SCK high", stab_ok, 1);
    check(cs_ok, "R11 CS held through frame", cs_ok, 1);
    check(idle_ok, "R5 SCK/MOSI low after release", idle_ok, 1);
    check(t_rdy - t_cs == GAP - 1, "R9 ready after gap", t_rdy - t_cs, GAP - 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired (R2 progress) actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int tc, tr;
    repeat (3) @(negedge clk);
    check(cs_n == 2'b11 && !sck && !mosi, "R1 reset outputs", {cs_n, sck, mosi}, 4'b1100);
    check(in_ready && !busy, "R1 reset ready", {in_ready, busy}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 2'b11 && in_ready && !rx_valid, "R1 idle after reset", {cs_n, in_ready}, 3'b111);

    for (int i = 0; i < 6; i++) begin
      offer(VEC[i][16], VEC[i][15:12], VEC[i][11:0]);
      in_valid = 1'b0;
      observe(VEC[i][16], exp_frame(VEC[i][16], VEC[i][15:12], VEC[i][11:0]), tc, tr);
    end

    // word held on the stream with another target during a transfer
    offer(1'b0, 4'hC, 12'h3E1);
    in_target = 1'b1; in_cmd = 4'h9; in_data = 12'hF96;
    observe(1'b0, exp_frame(1'b0, 4'hC, 12'h3E1), tc, tr);
    @(negedge clk);
    in_valid = 1'b0;
    check(cs_n == 2'b01, "R2 held word sent after ready", cs_n, 2'b01);
    check(tr + 1 - tc == GAP, "R9 CS high for exactly the gap", tr + 1 - tc, GAP);
    observe(1'b1, exp_frame(1'b1, 4'h9, 12'hF96), tc, tr);

    // back-to-back display then logic device
    offer(1'b1, 4'h0, 12'h100);
    in_target = 1'b0; in_cmd = 4'h1; in_data = 12'h001;
    observe(1'b1, 16'h0100, tc, tr);
    @(negedge clk);
    in_valid = 1'b0;
    check(cs_n == 2'b10, "R11 target switch on reload", cs_n, 2'b10);
    observe(1'b0, 16'h1001, tc, tr);

    repeat (5) @(negedge clk);
    check(cs_n == 2'b11 && in_ready && !busy, "R2 idle with no offer", {cs_n, in_ready, busy}, 4'b1110);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule